// File: doc/BRIEF.md
# Display RAM Port with Bus Holder

This block is the processor-facing side of a small display memory. A host talks to it over a parallel port: a select line picks between the command/status space and the data space, a write strobe and a read strobe mark one-cycle accesses, and an 8-bit bus carries data in each direction. Between the port and the memory sits a one-byte bus holder register. Every data byte passes through it in both directions.

On the write side, a data byte is captured into the holder and copied into the memory on the following clock. The copy goes to the column that was current when the byte arrived, and the column pointer then steps forward. On the read side, the port returns whatever the holder already contains and reloads the holder from the current column. As a result, the first data read after the column is set is a throw-away read. The byte stored at that column comes out on the second read. A command write loads the column pointer. After every accepted write the block stays busy for a fixed number of clocks. The host can see this on bit 7 of a status read, and it should poll that bit or pace its accesses.

The memory is a plain register array inside the block. The column pointer wraps from the last column back to zero. Reads advance the pointer in the same way that writes do.

Top module: `dram_holder_port`

## Requirements
- R1: After reset, `dout` is 0x00, the holder is 0x00, the column pointer is 0 and the block is not busy, so a status read returns 0x00.
- R2: A status read (`rd_stb`=1, `sel_data`=0, `wr_stb`=0) is accepted even while busy. From the next clock edge, `dout` shows the busy state sampled at that edge in bit 7, and bits 6..0 read 0.
- R3: An accepted command write (`wr_stb`=1, `sel_data`=0) loads the column pointer with `din` when `din` < COLS, and with 0 otherwise.
- R4: An accepted data write (`wr_stb`=1, `sel_data`=1) captures `din` into the holder and stores it at the current column one clock later. The column pointer then advances by one.
- R5: Every accepted write makes the block busy for exactly BUSY_CYC clocks. Consider a write accepted at edge t and a status read at edge t+1+k: it shows bit 7 set for k < BUSY_CYC and clear for k = BUSY_CYC.
- R6: A write of either kind presented while busy is dropped. It changes neither the memory, nor the holder, nor the column pointer.
- R7: An accepted data read (`rd_stb`=1, `sel_data`=1) puts the previous holder contents on `dout`, reloads the holder from the current column and advances the column pointer. The first read after a column set therefore returns stale data, and this is also true between consecutive column sets.
- R8: A data read presented while busy is ignored. `dout`, the holder and the column pointer keep their values.
- R9: The column pointer wraps from COLS-1 to 0, both on data writes and on data reads.
- R10: When `wr_stb` and `rd_stb` are high in the same cycle, the write is handled under the rules above and the read is ignored, so `dout` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_data | input | 1 | 1 selects the data space, 0 selects the command/status space |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| din | input | DW | Write data from the host |
| dout | output | DW | Read data to the host, held between reads |

## Verification
The assertions check the following on every clock edge:
- the busy window opens after each accepted write;
- the column pointer and the output stay frozen while busy;
- a status read reflects the busy state it sampled;
- a data read returns the holder contents from the cycle before;
- the pointer steps or loads correctly.

Some behaviours only show up in the bench scenarios, which model the memory separately:
- whether a byte actually reached the right column one clock after capture;
- the stale first read after every column set, including back-to-back sets;
- the exact edge at which busy ends;
- wrap-around of the stored contents, seen through later reads.

// File: rtl/dhp_pkg.sv
package dhp_pkg;

   // Decoded access kind, after busy gating
   typedef enum logic [2:0] {
      OP_NONE    = 3'd0,
      OP_CMD_WR  = 3'd1,
      OP_DATA_WR = 3'd2,
      OP_DATA_RD = 3'd3,
      OP_STAT_RD = 3'd4
   } dhp_op_e;

   function automatic logic is_write(input dhp_op_e op);
      return (op == OP_CMD_WR) || (op == OP_DATA_WR);
   endfunction

   function automatic logic is_data(input dhp_op_e op);
      return (op == OP_DATA_WR) || (op == OP_DATA_RD);
   endfunction

endpackage

// File: rtl/dhp_decode.sv
module dhp_decode
   import dhp_pkg::*;
(
   input  logic    sel_data,
   input  logic    wr_stb,
   input  logic    rd_stb,
   input  logic    busy,
   output dhp_op_e op
);

   // The write strobe wins over the read strobe; while busy only status reads pass
   always_comb begin
      op = OP_NONE;
      if (wr_stb) begin
         if (!busy) begin
            op = sel_data ? OP_DATA_WR : OP_CMD_WR;
         end
      end else if (rd_stb) begin
         if (!sel_data) begin
            op = OP_STAT_RD;
         end else if (!busy) begin
            op = OP_DATA_RD;
         end
      end
   end

endmodule

// File: rtl/dhp_busy_timer.sv
module dhp_busy_timer #(
   parameter int BUSY_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int CW = $clog2(BUSY_CYC + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= CW'(BUSY_CYC);
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != '0);

endmodule

// File: rtl/dhp_col_ctr.sv
module dhp_col_ctr #(
   parameter int COLS = 102,
   parameter int AW   = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] col
);

   logic [AW-1:0] col_nxt;

   // A power-of-two column count wraps naturally; any other count needs a compare
   generate
      if ((64'd1 << AW) == 64'(COLS)) begin : g_wrap_pow2
         assign col_nxt = col + 1'b1;
      end else begin : g_wrap_cmp
         assign col_nxt = (col == AW'(COLS - 1)) ? '0 : col + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col <= '0;
      end else if (load) begin
         col <= load_val;
      end else if (step) begin
         col <= col_nxt;
      end
   end

endmodule

// File: rtl/dhp_store.sv
module dhp_store #(
   parameter int COLS = 102,
   parameter int DW   = 8,
   parameter int AW   = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] col,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] holder
);

   logic [DW-1:0] mem [COLS];
   logic          pend;
   logic [AW-1:0] pend_col;

   // Holder: filled from the host on a data write, from the array on a data read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         holder   <= '0;
         pend     <= 1'b0;
         pend_col <= '0;
      end else begin
         pend <= wr_en;
         if (wr_en) begin
            holder   <= din;
            pend_col <= col;
         end else if (rd_en) begin
            holder <= mem[col];
         end
      end
   end

   // Second stage of a write: holder contents move into the array
   always_ff @(posedge clk) begin
      if (pend) begin
         mem[pend_col] <= holder;
      end
   end

endmodule

// File: rtl/dram_holder_port.sv
module dram_holder_port
   import dhp_pkg::*;
#(
   parameter int COLS     = 102,
   parameter int DW       = 8,
   parameter int BUSY_CYC = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_data,
   input  logic          wr_stb,
   input  logic          rd_stb,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);

   localparam int AW = (COLS > 1) ? $clog2(COLS) : 1;

   // Elaboration-time parameter checks
   generate
      if (COLS < 2) begin : g_bad_cols
         initial $fatal(1, "COLS must be at least 2");
      end
      if (DW < AW || DW > 32) begin : g_bad_dw
         initial $fatal(1, "DW must hold a column index and be at most 32");
      end
      if (BUSY_CYC < 1) begin : g_bad_busy
         initial $fatal(1, "BUSY_CYC must be at least 1");
      end
   endgenerate

   dhp_op_e       op;
   logic          busy;
   logic [AW-1:0] col;
   logic [AW-1:0] load_col;
   logic [DW-1:0] holder;

   dhp_decode u_decode (
      .sel_data (sel_data),
      .wr_stb   (wr_stb),
      .rd_stb   (rd_stb),
      .busy     (busy),
      .op       (op)
   );

   dhp_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (is_write(op)),
      .busy  (busy)
   );

   // Out-of-range column requests select column 0
   always_comb begin
      if (32'(din) < COLS) begin
         load_col = din[AW-1:0];
      end else begin
         load_col = '0;
      end
   end

   dhp_col_ctr #(.COLS(COLS), .AW(AW)) u_col (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (op == OP_CMD_WR),
      .load_val (load_col),
      .step     (is_data(op)),
      .col      (col)
   );

   dhp_store #(.COLS(COLS), .DW(DW), .AW(AW)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (op == OP_DATA_WR),
      .rd_en  (op == OP_DATA_RD),
      .col    (col),
      .din    (din),
      .holder (holder)
   );

   // Output register: previous holder on data reads, busy in the top bit on status reads
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
      end else if (op == OP_DATA_RD) begin
         dout <= holder;
      end else if (op == OP_STAT_RD) begin
         dout <= {busy, {(DW-1){1'b0}}};
      end
   end

endmodule

// File: rtl/dhp_checker.sv
module dhp_checker
   import dhp_pkg::*;
#(
   parameter int COLS     = 102,
   parameter int DW       = 8,
   parameter int BUSY_CYC = 4,
   parameter int AW       = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sel_data,
   input logic          wr_stb,
   input logic          rd_stb,
   input logic [DW-1:0] din,
   input logic [DW-1:0] dout,
   input dhp_op_e       op,
   input logic          busy,
   input logic [AW-1:0] col,
   input logic [DW-1:0] holder
);

   // R5: an accepted write opens the busy window
   a_r5_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      is_write(op) |=> busy);

   // R6: a write seen while busy leaves the column pointer alone
   a_r6_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_stb) |=> $stable(col));

   // R8: a data read seen while busy leaves output and pointer alone
   a_r8_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_stb && sel_data && !wr_stb) |=> ($stable(dout) && $stable(col)));

   // R2: a status read reports the busy state it sampled
   a_r2_status_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !wr_stb && !sel_data) |=> (dout == {$past(busy), {(DW-1){1'b0}}}));

   // R7: a data read returns the holder from the cycle before
   a_r7_read_holder: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DATA_RD) |=> (dout == $past(holder)));

   // R4, R9: a data access steps the pointer with wrap
   a_r4_col_step: assert property (@(posedge clk) disable iff (!rst_n)
      is_data(op) |=> (col == (($past(col) == AW'(COLS - 1)) ? '0 : $past(col) + 1'b1)));

   // R3: a command write loads the pointer, out-of-range giving 0
   a_r3_col_load: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CMD_WR) |=> (col == ((32'($past(din)) < COLS) ? $past(din[AW-1:0]) : '0)));

   // R10: with both strobes high the read has no effect on the output
   a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && rd_stb) |=> $stable(dout));

endmodule

bind dram_holder_port dhp_checker #(
   .COLS(COLS), .DW(DW), .BUSY_CYC(BUSY_CYC), .AW(AW)
) u_dhp_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_data (sel_data),
   .wr_stb   (wr_stb),
   .rd_stb   (rd_stb),
   .din      (din),
   .dout     (dout),
   .op       (op),
   .busy     (busy),
   .col      (col),
   .holder   (holder)
);

// File: tb/dram_holder_port_tb_top.sv
module dram_holder_port_tb_top;

   localparam int COLS     = 102;
   localparam int DW       = 8;
   localparam int BUSY_CYC = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic          sel_data;
   logic          wr_stb;
   logic          rd_stb;
   logic [DW-1:0] din;
   logic [DW-1:0] dout;

   dram_holder_port #(.COLS(COLS), .DW(DW), .BUSY_CYC(BUSY_CYC)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_data (sel_data),
      .wr_stb   (wr_stb),
      .rd_stb   (rd_stb),
      .din      (din),
      .dout     (dout)
   );

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [DW-1:0] val;
      string         tag;
   } exp_t;
   exp_t sb_q[$];

   // Reference model state
   logic [DW-1:0] m_mem [COLS];
   int            m_col  = 0;
   logic [DW-1:0] m_hold = '0;
   logic [DW-1:0] m_last = '0;
   int            m_cnt  = 0;

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: dout=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // Monitor: after each edge that saw a read strobe, compare against the scoreboard
   logic rd_q = 1'b0;
   always @(posedge clk) rd_q <= rd_stb && rst_n;

   always @(negedge clk) begin
      if (rd_q) begin
         if (sb_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: dout=%02h expected=none", dout);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, dout, e.val);
         end
      end
   end

   // Driver: one clock of stimulus, with the model updated from the requirements
   task automatic cyc(input bit a0, input bit w, input bit r, input logic [DW-1:0] d, input string tag);
      bit   bsy;
      exp_t e;
      @(negedge clk);
      sel_data = a0;
      wr_stb   = w;
      rd_stb   = r;
      din      = d;
      bsy      = (m_cnt != 0);
      if (w && !bsy) begin
         if (a0) begin
            m_mem[m_col] = d;
            m_hold       = d;
            m_col        = (m_col + 1) % COLS;
         end else begin
            m_col = (int'(d) < COLS) ? int'(d) : 0;
         end
      end
      if (r) begin
         if (w) begin
            e.val = m_last;
         end else if (!a0) begin
            e.val = {bsy, {(DW-1){1'b0}}};
         end else if (bsy) begin
            e.val = m_last;
         end else begin
            e.val  = m_hold;
            m_hold = m_mem[m_col];
            m_col  = (m_col + 1) % COLS;
         end
         m_last = e.val;
         e.tag  = tag;
         sb_q.push_back(e);
      end
      if (w && !bsy) m_cnt = BUSY_CYC;
      else if (m_cnt > 0) m_cnt--;
      @(posedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, '0, "idle");
   endtask

   task automatic set_col(input logic [DW-1:0] c);
      cyc(1'b0, 1'b1, 1'b0, c, "R3");
      idle(BUSY_CYC);
   endtask

   task automatic put(input logic [DW-1:0] d);
      cyc(1'b1, 1'b1, 1'b0, d, "R4");
      idle(BUSY_CYC);
   endtask

   task automatic get(input string tag);
      cyc(1'b1, 1'b0, 1'b1, '0, tag);
   endtask

   task automatic stat(input string tag);
      cyc(1'b0, 1'b0, 1'b1, '0, tag);
   endtask

   task automatic finish_run;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      rst_n    = 1'b0;
      sel_data = 1'b0;
      wr_stb   = 1'b0;
      rd_stb   = 1'b0;
      din      = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset dout", dout, '0);
      stat("R1 status after reset");
      // R1: holder starts at zero, column at zero: dummy read gives 0x00
      get("R1 holder reset");

      // R4, R9: fill every column, then one more byte wraps to column 0
      set_col('0);
      for (int i = 0; i < COLS; i++) put(DW'(i * 7 + 3));
      put(8'hEE);

      // R7: stale first read after a column set, then stored bytes in order
      set_col(8'd5);
      get("R7 dummy read");
      get("R7 col5");
      get("R7 col6");
      get("R7 col7");

      // R5, R2: busy edge, status read accepted while busy
      cyc(1'b0, 1'b1, 1'b0, 8'd10, "R3");
      idle(BUSY_CYC - 1);
      stat("R5 busy last cycle");
      stat("R5 busy cleared");

      // R6: a data write during busy is dropped
      cyc(1'b0, 1'b1, 1'b0, 8'd10, "R3");
      cyc(1'b1, 1'b1, 1'b0, 8'hAA, "R6");
      idle(BUSY_CYC);
      set_col(8'd10);
      get("R6 dummy");
      get("R6 col10 unchanged");

      // R8: a data read during busy is ignored
      cyc(1'b0, 1'b1, 1'b0, 8'd20, "R3");
      get("R8 read while busy");
      idle(BUSY_CYC);
      get("R8 dummy after busy");
      get("R8 col20");

      // R7: consecutive column sets, each needs its own dummy read
      set_col(8'd3);
      get("R7 dummy col3");
      set_col(8'd8);
      get("R7 stale after second set");
      get("R7 col8");

      // R3: out-of-range column request selects column 0
      set_col(8'd200);
      get("R3 dummy");
      get("R3 col0 after range clamp");

      // R9: reads wrap from the last column to column 0
      set_col(8'(COLS - 1));
      get("R9 dummy");
      get("R9 last col");
      get("R9 wrapped col0");

      // R10: both strobes together, the write wins and the read is ignored
      set_col(8'd30);
      cyc(1'b1, 1'b1, 1'b1, 8'h5A, "R10 read ignored");
      idle(BUSY_CYC);
      set_col(8'd30);
      get("R10 dummy");
      get("R10 col30 written");

      idle(3);
      if (sb_q.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL scoreboard: %0d expected reads left, expected 0", sb_q.size());
      end
      finish_run();
   end

endmodule